// File: doc/BRIEF.md
# Chainable 16-bit SPI Slave with Pipelined Answer

This block is the serial front end of a driver chip. A host talks to it over a four-wire SPI link (chip select, clock, data in, data out with a drive enable). Every frame is 16 bits. When several devices share one select line in a chain, a frame is a multiple of 16 bits. The block runs on a system clock. It passes chip select, serial clock and data in through synchronizers and finds their edges in that clock domain.

The word a host sends in one transfer takes effect when chip select rises. The word the host reads back is the answer to the previous transfer. After reset that answer is a fixed identifier. After a good frame it is a snapshot of the diagnosis input taken at the end of that frame. After a frame with a broken clock count it is all zeros. A frame with no clock edges at all is harmless: it changes nothing. In the gap between chip select falling and the first clock edge, the data line shows a single fault-summary bit. The host can therefore poll for faults without clocking. A one-cycle read strobe tells the diagnosis logic that its word has been read.

Top module: `spi_chain_slave`

## Requirements
- R1: spi_sdo_oe_o is low while chip select is high or during reset, and high while chip select is low.
- R2: After chip select falls and before the first SCK rising edge of the transfer, spi_sdo_o equals fault_sum_i.
- R3: The first answer after reset is the DEVICE_ID parameter (default 16'h3C81).
- R4: Answers are shifted out MSB first. The output bit changes after each SCK rising edge, and spi_sdi_i is sampled at each SCK falling edge. The answer in transfer N+1 is the value of diag_i at the end of transfer N, when transfer N had a nonzero multiple of 16 falling edges.
- R5: The configuration output reads 16'h0008 after reset. At the end of a good transfer it takes the last 16 bits received, masked to the writable fields: bit 1 diagnosis-clear mode, bits 3:2 current level, bit 8 voltage slew, bit 9 current slew, bit 10 current-slew bypass, bit 11 on-state open-load check. All other bits read 0, so the mask is 16'h0F0E.
- R6: A transfer with no SCK edges leaves the configuration unchanged, keeps the pending answer for the next transfer, and issues no read strobe.
- R7: A transfer whose falling-edge count is not a nonzero multiple of 16 leaves the configuration unchanged, issues no read strobe, and makes the next answer 16'h0000.
- R8: In a transfer longer than 16 bits, spi_sdo_o repeats spi_sdi_i delayed by 16 bits after the first 16 answer bits, and the configuration is taken from the final 16 bits received.
- R9: diag_rd_o pulses for exactly one clock cycle after each good transfer, and at no other time.
- R10: The configuration output does not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock, idle low |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Drive enable for serial data out |
| fault_sum_i | input | 1 | Fault summary bit shown before the first clock |
| diag_i | input | FRAME_W | Diagnosis word from the fault logic |
| diag_rd_o | output | 1 | One-cycle strobe: diagnosis word has been read |
| cfg_o | output | FRAME_W | Configuration register |

## Verification
The bench runs a zero-clock frame, then checks that the next frame returns the old pending answer. A design that overwrote the answer would show up there. It runs frames of 5 and 17 clocks and expects an all-zero answer afterward with no strobe and no configuration change. A design that latched a partial frame, or counted modulo 16 without the nonzero test, fails these checks. A 32-bit chained frame checks that the first received word reappears on the output and that the configuration comes from the second word. An off-by-one in the shift path or latching the wrong half of the frame would break this. The bench also checks the identifier on the first frame, the fault bit before the first clock, and that the configuration holds while chip select is low.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  typedef enum logic [1:0] {
    FR_EMPTY = 2'd0,
    FR_GOOD  = 2'd1,
    FR_BAD   = 2'd2
  } frame_verdict_e;

  // field positions of the configuration word
  localparam int unsigned POS_CLR_MODE  = 1;
  localparam int unsigned POS_ILIM_LO   = 2;
  localparam int unsigned POS_ILIM_HI   = 3;
  localparam int unsigned POS_VSLEW     = 8;
  localparam int unsigned POS_ISLEW     = 9;
  localparam int unsigned POS_ISLEW_OFF = 10;
  localparam int unsigned POS_OL_ON     = 11;

  localparam logic [15:0] CFG_MASK =
      (16'd1 << POS_CLR_MODE) | (16'd1 << POS_ILIM_LO) | (16'd1 << POS_ILIM_HI) |
      (16'd1 << POS_VSLEW) | (16'd1 << POS_ISLEW) | (16'd1 << POS_ISLEW_OFF) |
      (16'd1 << POS_OL_ON);

  localparam logic [15:0] CFG_RESET = 16'd1 << POS_ILIM_HI;

endpackage

// File: rtl/spi_sync_bits.sv
module spi_sync_bits #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_chain_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_s_i,
  input  logic               sck_s_i,
  input  logic               sdi_s_i,
  input  logic               fault_sum_i,
  input  logic [FRAME_W-1:0] ans_i,
  output logic [FRAME_W-1:0] rx_o,
  output logic               cs_rise_o,
  output frame_verdict_e     verdict_o,
  output logic               sdo_o,
  output logic               sdo_oe_o
);

  logic cs_d, sck_d;
  logic cs_fall, cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0] cnt_q;
  logic any_fall_q, any_edge_q, started_q, so_q;
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s_i;
      sck_d <= sck_s_i;
    end
  end

  assign cs_fall  = cs_d & ~cs_s_i;
  assign cs_rise  = ~cs_d & cs_s_i;
  assign sck_rise = ~cs_s_i & sck_s_i & ~sck_d;
  assign sck_fall = ~cs_s_i & ~sck_s_i & sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      any_fall_q <= 1'b0;
      any_edge_q <= 1'b0;
      started_q  <= 1'b0;
      so_q       <= 1'b0;
    end else if (cs_fall) begin
      sr_q       <= ans_i;
      cnt_q      <= '0;
      any_fall_q <= 1'b0;
      any_edge_q <= 1'b0;
      started_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        so_q       <= sr_q[FRAME_W-1];
        started_q  <= 1'b1;
        any_edge_q <= 1'b1;
      end
      if (sck_fall) begin
        // one shift path serves both answer out and chain pass-through
        sr_q       <= {sr_q[FRAME_W-2:0], sdi_s_i};
        cnt_q      <= (cnt_q == CNT_W'(FRAME_W - 1)) ? '0 : cnt_q + 1'b1;
        any_fall_q <= 1'b1;
        any_edge_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!any_edge_q)                     verdict_o = FR_EMPTY;
    else if (any_fall_q && cnt_q == '0)  verdict_o = FR_GOOD;
    else                                 verdict_o = FR_BAD;
  end

  assign rx_o      = sr_q;
  assign cs_rise_o = cs_rise;
  assign sdo_oe_o  = ~cs_s_i;
  assign sdo_o     = ~cs_s_i & (started_q ? so_q : fault_sum_i);

  a_r1_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && cs_d) |-> (!sdo_oe_o && !sdo_o));

  a_r8_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall && !cs_fall) |=> (sr_q[0] == $past(sdi_s_i)));

endmodule

// File: rtl/spi_reply_cfg.sv
module spi_reply_cfg
  import spi_chain_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter logic [FRAME_W-1:0] DEVICE_ID = 16'h3C81
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_rise_i,
  input  frame_verdict_e     verdict_i,
  input  logic [FRAME_W-1:0] rx_i,
  input  logic [FRAME_W-1:0] diag_i,
  output logic [FRAME_W-1:0] ans_o,
  output logic [FRAME_W-1:0] cfg_o,
  output logic               rd_o
);

  localparam logic [FRAME_W-1:0] MASK  = FRAME_W'(CFG_MASK);
  localparam logic [FRAME_W-1:0] RST_V = FRAME_W'(CFG_RESET);

  logic [FRAME_W-1:0] ans_q, cfg_q;
  logic rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ans_q <= DEVICE_ID;
      cfg_q <= RST_V;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      if (cs_rise_i) begin
        unique case (verdict_i)
          FR_GOOD: begin
            cfg_q <= rx_i & MASK;
            ans_q <= diag_i;
            rd_q  <= 1'b1;
          end
          FR_BAD:  ans_q <= '0;
          default: ;
        endcase
      end
    end
  end

  assign ans_o = ans_q;
  assign cfg_o = cfg_q;
  assign rd_o  = rd_q;

  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);

  a_r9_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> $past(cs_rise_i && verdict_i == FR_GOOD));

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(cfg_q));

  a_r6_empty_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && verdict_i == FR_EMPTY) |=> ($stable(ans_q) && $stable(cfg_q)));

  a_r7_bad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && verdict_i == FR_BAD) |=> (ans_q == '0 && $stable(cfg_q)));

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [FRAME_W-1:0] DEVICE_ID = 16'h3C81
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               spi_cs_ni,
  input  logic               spi_sck_i,
  input  logic               spi_sdi_i,
  output logic               spi_sdo_o,
  output logic               spi_sdo_oe_o,
  input  logic               fault_sum_i,
  input  logic [FRAME_W-1:0] diag_i,
  output logic               diag_rd_o,
  output logic [FRAME_W-1:0] cfg_o
);

  logic [2:0] pins_s;
  logic [FRAME_W-1:0] rx, ans;
  logic cs_rise;
  frame_verdict_e verdict;

  // order {sdi, sck, cs}; select idles high
  spi_sync_bits #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_sdi_i, spi_sck_i, spi_cs_ni}),
    .q_o   (pins_s)
  );

  spi_frame_ctrl #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (pins_s[0]),
    .sck_s_i    (pins_s[1]),
    .sdi_s_i    (pins_s[2]),
    .fault_sum_i(fault_sum_i),
    .ans_i      (ans),
    .rx_o       (rx),
    .cs_rise_o  (cs_rise),
    .verdict_o  (verdict),
    .sdo_o      (spi_sdo_o),
    .sdo_oe_o   (spi_sdo_oe_o)
  );

  spi_reply_cfg #(.FRAME_W(FRAME_W), .DEVICE_ID(DEVICE_ID)) u_reply (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_rise_i(cs_rise),
    .verdict_i(verdict),
    .rx_i     (rx),
    .diag_i   (diag_i),
    .ans_o    (ans),
    .cfg_o    (cfg_o),
    .rd_o     (diag_rd_o)
  );

endmodule

// File: tb/spi_chain_slave_bench.sv
module spi_chain_slave_bench;

  localparam int HALF = 8;
  localparam logic [15:0] ID   = 16'h3C81;
  localparam logic [15:0] MASK = 16'h0F0E;

  typedef struct {
    logic [63:0] bits;
    int          n;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, fault_sum = 1'b0;
  logic [15:0] diag = '0;
  logic sdo, sdo_oe, diag_rd;
  logic [15:0] cfg;

  int n_chk = 0, n_fail = 0, rd_cnt = 0, rd_exp = 0;
  bit done = 0;
  logic [15:0] cfg_model = 16'h0008;
  logic [15:0] ans_model = ID;
  item_t exp_q[$], act_q[$];

  always #5 clk = ~clk;

  spi_chain_slave u_spi_chain_slave (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sck_i(sck),
    .spi_sdi_i(sdi), .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
    .fault_sum_i(fault_sum), .diag_i(diag), .diag_rd_o(diag_rd), .cfg_o(cfg)
  );

  always @(posedge clk) if (diag_rd) rd_cnt++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare captured answers against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t a, e;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        chk({e.tag, " answer"}, a.bits, e.bits);
      end
    end
  end

  task automatic xfer(input int n, input logic [63:0] tx, input string tag);
    item_t e, a;
    logic [63:0] cap = '0;
    logic [63:0] ex = '0;
    for (int i = n - 1; i >= 0; i--) begin
      int k = n - 1 - i;
      ex[i] = (k < 16) ? ans_model[15-k] : tx[n-1-(k-16)];
    end
    e.bits = ex; e.n = n; e.tag = tag;
    if (n > 0) exp_q.push_back(e);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R1 oe low-cs", {63'd0, sdo_oe}, 64'd1);
    chk("R2 fault bit", {63'd0, sdo}, {63'd0, fault_sum});
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b1; sdi = tx[i];
      repeat (HALF) @(negedge clk);
      cap[i] = sdo;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    chk("R10 cfg held", {48'd0, cfg}, {48'd0, cfg_model});
    cs_n = 1'b1;
    if (n == 0) begin
    end else if (n % 16 == 0) begin
      cfg_model = tx[15:0] & MASK;
      ans_model = diag;
      rd_exp++;
    end else begin
      ans_model = '0;
    end
    repeat (HALF) @(negedge clk);
    chk("R1 oe high-cs", {63'd0, sdo_oe}, 64'd0);
    chk({tag, " cfg"}, {48'd0, cfg}, {48'd0, cfg_model});
    chk({tag, " R9 strobes"}, 64'(rd_cnt), 64'(rd_exp));
    a.bits = cap; a.n = n; a.tag = tag;
    if (n > 0) act_q.push_back(a);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R1..R10 incomplete) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset oe", {63'd0, sdo_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 reset cfg", {48'd0, cfg}, 64'h0008);
    chk("R9 no strobe idle", 64'(rd_cnt), 64'd0);

    fault_sum = 1'b1; diag = 16'h1234;
    xfer(16, 64'hFFFF, "R3");        // identifier; all-ones masked to 0F0E
    diag = 16'hBEEF;
    xfer(16, 64'h0004, "R4");        // answers 1234
    diag = 16'h7777;
    xfer(0, 64'h0, "R6");            // zero clocks
    fault_sum = 1'b0;
    xfer(16, 64'h0906, "R6");        // still BEEF
    xfer(5, 64'h1F, "R7");           // bad count
    xfer(16, 64'h0102, "R7");        // zero answer expected
    diag = 16'hC3A5;
    xfer(32, {32'd0, 16'hA5A5, 16'h0C02}, "R8");
    xfer(17, 64'h1FFFF, "R7");
    diag = 16'h0F0F;
    xfer(16, 64'h0008, "R7");
    xfer(48, {16'd0, 16'h1111, 16'h2222, 16'h0E0A}, "R8");
    xfer(16, 64'h0000, "R4");

    repeat (20) @(negedge clk);
    chk("R9 total strobes", 64'(rd_cnt), 64'(rd_exp));
    chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule